// File: doc/BRIEF.md
# Serial Clock Pulse-Width Reset Detector

This block watches the serial clock line of a converter-style serial slave port and raises a one-cycle reset request when the host drives a special pattern on that line. The pattern is three long high pulses with short low gaps between them. The first pulse is short, the second is medium and the third is long. Each pulse must fall inside its own length window, and each window is measured in periods of the device's oscillator clock. With this pattern a host can recover a stuck interface without a reset pin or a command byte.

The serial clock is asynchronous to the oscillator. It passes through a two-flop synchronizer, then an edge detector. Two saturating counters measure each high pulse and each low gap. A small sequencer checks every finished pulse against the window for its position in the sequence. Normal command clocking has periods of only a few oscillator cycles, so it never produces a qualifying pulse and the sequencer stays idle.

The reset request is a control pin. It goes to the device's reset logic, and the sequence position is brought out for debug. Neither output has back-pressure: the request is a single-cycle strobe that the receiver must act on.

Top module: `sclk_reset_detect`

## Requirements
- R1: After `rst_n` is released, `rst_req` is 0 and `seq_state` is 0. `seq_state` encodes 0 = idle, 1 = first pulse accepted, 2 = second pulse accepted; the value 3 never appears.
- R2: A pulse length is the number of rising `clk` edges at which `sclk` is sampled high. From idle, a pulse of length L with P1_MIN < L < P1_MAX moves `seq_state` to 1. Any other length leaves it at 0.
- R3: From state 1, a pulse with P2_MIN < L < P2_MAX moves `seq_state` to 2. State 2 is reachable only from state 1.
- R4: From state 2, a pulse with P3_MIN < L < P3_MAX raises `rst_req` for exactly one cycle. The rise happens on the second rising `clk` edge after the edge that first samples `sclk` low at the end of that pulse.
- R5: A low gap is the number of rising `clk` edges at which `sclk` is sampled low. A second or third pulse counts only if the gap before it is greater than GAP_MIN. After a shorter gap, that pulse is judged as a first pulse instead.
- R6: When a pulse misses the window expected in state 1 or 2, the same pulse is checked against the first window. If it fits, `seq_state` becomes 1; otherwise it becomes 0.
- R7: The pulse and gap counters saturate at 2^CNT_W-1, which is above P3_MAX. A high level longer than that never qualifies, even when its length modulo 2^CNT_W would fall in a window.
- R8: After `rst_req` fires, `seq_state` is 0. Another request needs all three pulses again.
- R9: Continuous `sclk` toggling with high and low times of at most P1_MIN oscillator periods keeps `seq_state` at 0 and `rst_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sclk | input | 1 | Serial clock line, asynchronous to `clk` |
| rst_req | output | 1 | One-cycle reset request |
| seq_state | output | 2 | Debug: current position in the pulse sequence |

## Verification
The bench scales the windows down to 6..10, 12..16 and 20..24 oscillator periods, with a minimum gap of 2. This makes the counter 5 bits wide, so it saturates at 31. At this size the bench can sweep every pulse length from 1 to 30 at each of the three sequence positions, and every gap length near the threshold. It can also drive a high level of 54 periods, which would land inside the third window if the counter wrapped instead of saturating. Fast toggling at two- and four-cycle periods checks that normal command clocking never leaves idle.

// File: rtl/sclkrst_pkg.sv
package sclkrst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2
  } seq_e;

endpackage

// File: rtl/sclkrst_sync.sv
// Synchronizes the serial clock and flags its edges. The level used for
// counting is one flop behind the synchronizer output so that edges and
// counting line up.
module sclkrst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      dly   <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], sclk};
      dly   <= chain[STAGES-1];
    end
  end

  assign lvl  = dly;
  assign rise = chain[STAGES-1] & ~dly;
  assign fall = ~chain[STAGES-1] & dly;

endmodule

// File: rtl/sclkrst_meter.sv
// Saturating run-length counter: loads 1 on start, then counts each cycle
// the watched level stays active, stopping at the all-ones value.
module sclkrst_meter #(
  parameter int CW         = 11,
  parameter bit RESET_FULL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  output logic [CW-1:0] len
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] RST = RESET_FULL ? TOP : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    len <= RST;
    else if (start)                len <= ONE;
    else if (active && len != TOP) len <= len + ONE;
  end

endmodule

// File: rtl/sclkrst_seq.sv
// Pulse sequencer: judges every finished high pulse against the window
// for the current position and fires the request on the third.
module sclkrst_seq
  import sclkrst_pkg::*;
#(
  parameter int CW      = 11,
  parameter int P1_MIN  = 300,
  parameter int P1_MAX  = 500,
  parameter int P2_MIN  = 550,
  parameter int P2_MAX  = 750,
  parameter int P3_MIN  = 1050,
  parameter int P3_MAX  = 1250,
  parameter int GAP_MIN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic [CW-1:0] hi_len,
  input  logic [CW-1:0] lo_len,
  output logic          fire,
  output seq_e          state
);

  localparam logic [CW-1:0] A_LO = CW'(P1_MIN);
  localparam logic [CW-1:0] A_HI = CW'(P1_MAX);
  localparam logic [CW-1:0] B_LO = CW'(P2_MIN);
  localparam logic [CW-1:0] B_HI = CW'(P2_MAX);
  localparam logic [CW-1:0] C_LO = CW'(P3_MIN);
  localparam logic [CW-1:0] C_HI = CW'(P3_MAX);
  localparam logic [CW-1:0] G_LO = CW'(GAP_MIN);

  logic gap_ok;
  logic fit_a, fit_b, fit_c;
  seq_e nxt;
  logic nxt_fire;

  assign fit_a = (hi_len > A_LO) && (hi_len < A_HI);
  assign fit_b = (hi_len > B_LO) && (hi_len < B_HI);
  assign fit_c = (hi_len > C_LO) && (hi_len < C_HI);

  always_comb begin
    nxt      = state;
    nxt_fire = 1'b0;
    if (fall) begin
      unique case (state)
        SEQ_ONE: begin
          if (gap_ok && fit_b) nxt = SEQ_TWO;
          else if (fit_a)      nxt = SEQ_ONE;
          else                 nxt = SEQ_IDLE;
        end
        SEQ_TWO: begin
          if (gap_ok && fit_c) begin
            nxt      = SEQ_IDLE;
            nxt_fire = 1'b1;
          end else if (fit_a) nxt = SEQ_ONE;
          else                nxt = SEQ_IDLE;
        end
        default: nxt = fit_a ? SEQ_ONE : SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      fire   <= 1'b0;
      gap_ok <= 1'b0;
    end else begin
      state <= nxt;
      fire  <= nxt_fire;
      if (rise) gap_ok <= (lo_len > G_LO);
    end
  end

endmodule

// File: rtl/sclk_reset_detect.sv
module sclk_reset_detect
  import sclkrst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int P1_MIN      = 300,
  parameter int P1_MAX      = 500,
  parameter int P2_MIN      = 550,
  parameter int P2_MAX      = 750,
  parameter int P3_MIN      = 1050,
  parameter int P3_MAX      = 1250,
  parameter int GAP_MIN     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  output logic       rst_req,
  output logic [1:0] seq_state
);

  localparam int CNT_W = $clog2(P3_MAX + 2);

  logic             sclk_lvl, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] hi_len, lo_len;
  seq_e             st;

  sclkrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n(rst_n), .sclk(sclk),
    .lvl (sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  sclkrst_meter #(.CW(CNT_W), .RESET_FULL(1'b0)) u_hi (
    .clk(clk), .rst_n(rst_n), .start(sclk_rise), .active(sclk_lvl), .len(hi_len)
  );

  sclkrst_meter #(.CW(CNT_W), .RESET_FULL(1'b1)) u_lo (
    .clk(clk), .rst_n(rst_n), .start(sclk_fall), .active(~sclk_lvl), .len(lo_len)
  );

  sclkrst_seq #(
    .CW(CNT_W),
    .P1_MIN(P1_MIN), .P1_MAX(P1_MAX),
    .P2_MIN(P2_MIN), .P2_MAX(P2_MAX),
    .P3_MIN(P3_MIN), .P3_MAX(P3_MAX),
    .GAP_MIN(GAP_MIN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .fall(sclk_fall),
    .hi_len(hi_len), .lo_len(lo_len), .fire(rst_req), .state(st)
  );

  assign seq_state = st;

endmodule

// File: rtl/sclk_reset_detect_chk.sv
module sclk_reset_detect_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic [1:0]    seq_state,
  input logic          sclk_lvl,
  input logic [CW-1:0] hi_len,
  input logic [CW-1:0] lo_len
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state != 2'd3);

  // R3
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd2 && $past(seq_state) != 2'd2) |-> $past(seq_state) == 2'd1);

  // R4
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R4
  req_from_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(seq_state) == 2'd2);

  // R8
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> seq_state == 2'd0);

  // R7
  hi_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_len == TOP && sclk_lvl) |=> hi_len == TOP);

  // R7
  lo_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_len == TOP && !sclk_lvl) |=> lo_len == TOP);

endmodule

bind sclk_reset_detect sclk_reset_detect_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .seq_state(seq_state),
  .sclk_lvl(sclk_lvl), .hi_len(hi_len), .lo_len(lo_len)
);

// File: tb/sclk_reset_detect_bench.sv
`timescale 1ns/1ps
module sclk_reset_detect_bench;

  localparam int A_LO = 6,  A_HI = 10;
  localparam int B_LO = 12, B_HI = 16;
  localparam int C_LO = 20, C_HI = 24;
  localparam int GAP  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       rst_req;
  logic [1:0] seq_state;

  int tests = 0, fails = 0, fires = 0, fast_bad = 0;
  bit fast_mode = 1'b0;

  always #5 clk = ~clk;

  sclk_reset_detect #(
    .P1_MIN(A_LO), .P1_MAX(A_HI), .P2_MIN(B_LO), .P2_MAX(B_HI),
    .P3_MIN(C_LO), .P3_MAX(C_HI), .GAP_MIN(GAP)
  ) u_sclk_reset_detect (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rst_req(rst_req), .seq_state(seq_state)
  );

  always @(negedge clk) begin
    if (rst_req) fires++;
    if (fast_mode && (seq_state != 2'd0 || rst_req)) fast_bad++;
  end

  function automatic bit in_w(int l, int lo, int hi);
    return (l > lo) && (l < hi);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int len, int gap);
    @(negedge clk) sclk = 1'b1;
    repeat (len) @(posedge clk);
    @(negedge clk) sclk = 1'b0;
    repeat (gap) @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    pulse(2, 6);
  endtask

  initial begin
    #2_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(rst_req == 1'b0, "R1 rst_req", int'(rst_req), 0);
    chk(seq_state == 2'd0, "R1 seq_state", int'(seq_state), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(seq_state == 2'd0, "R1 after release", int'(seq_state), 0);

    // R2 first-window sweep
    for (int l = 1; l <= 30; l++) begin
      pulse(l, 6);
      chk(int'(seq_state) == (in_w(l, A_LO, A_HI) ? 1 : 0), "R2 first window", int'(seq_state), in_w(l, A_LO, A_HI) ? 1 : 0);
      go_idle();
    end

    // R3 / R6 second-window sweep
    for (int l = 1; l <= 30; l++) begin
      int e;
      pulse(8, 4);
      pulse(l, 6);
      e = in_w(l, B_LO, B_HI) ? 2 : (in_w(l, A_LO, A_HI) ? 1 : 0);
      chk(int'(seq_state) == e, "R3 R6 second window", int'(seq_state), e);
      go_idle();
    end

    // R4 / R6 / R8 third-window sweep
    for (int l = 1; l <= 30; l++) begin
      int e;
      pulse(8, 4);
      pulse(14, 4);
      f0 = fires;
      pulse(l, 6);
      chk((fires - f0) == (in_w(l, C_LO, C_HI) ? 1 : 0), "R4 third window fire", fires - f0, in_w(l, C_LO, C_HI) ? 1 : 0);
      e = in_w(l, C_LO, C_HI) ? 0 : (in_w(l, A_LO, A_HI) ? 1 : 0);
      chk(int'(seq_state) == e, "R8 R6 state after third", int'(seq_state), e);
      go_idle();
    end

    // R5 gap sweep before second and third pulse
    for (int g = 1; g <= 5; g++) begin
      pulse(8, g);
      pulse(14, 6);
      chk(int'(seq_state) == (g > GAP ? 2 : 0), "R5 gap before second", int'(seq_state), g > GAP ? 2 : 0);
      go_idle();
      pulse(8, 4);
      pulse(14, g);
      f0 = fires;
      pulse(22, 6);
      chk((fires - f0) == (g > GAP ? 1 : 0), "R5 gap before third", fires - f0, g > GAP ? 1 : 0);
      go_idle();
    end
    // R5 R6 short gap, pulse restarts sequence
    pulse(8, 1);
    pulse(8, 6);
    chk(seq_state == 2'd1, "R5 R6 restart after short gap", int'(seq_state), 1);
    go_idle();

    // R4 latency and width
    pulse(8, 4);
    pulse(14, 4);
    f0 = fires;
    @(negedge clk) sclk = 1'b1;
    repeat (22) @(posedge clk);
    @(negedge clk) sclk = 1'b0;
    @(posedge clk);
    @(posedge clk); #1;
    chk(rst_req == 1'b0, "R4 not early", int'(rst_req), 0);
    @(posedge clk); #1;
    chk(rst_req == 1'b1, "R4 on time", int'(rst_req), 1);
    @(posedge clk); #1;
    chk(rst_req == 1'b0, "R4 one cycle", int'(rst_req), 0);
    chk((fires - f0) == 1, "R4 single pulse", fires - f0, 1);

    // R8 re-arm needs full sequence
    repeat (6) @(posedge clk);
    f0 = fires;
    pulse(22, 6);
    pulse(14, 4);
    pulse(22, 6);
    chk((fires - f0) == 0, "R8 no partial refire", fires - f0, 0);
    chk(seq_state == 2'd0, "R8 idle", int'(seq_state), 0);
    // reversed order
    pulse(22, 4);
    pulse(14, 4);
    pulse(8, 6);
    chk((fires - f0) == 0, "R3 reversed order", fires - f0, 0);
    chk(seq_state == 2'd1, "R6 reversed ends on first", int'(seq_state), 1);
    go_idle();

    // R7 saturation: 54 mod 32 = 22 would hit third window if wrapped
    pulse(8, 4);
    pulse(14, 4);
    f0 = fires;
    pulse(54, 6);
    chk((fires - f0) == 0, "R7 long third no fire", fires - f0, 0);
    chk(seq_state == 2'd0, "R7 long idle", int'(seq_state), 0);
    pulse(40, 6);
    chk(seq_state == 2'd0, "R7 long first", int'(seq_state), 0);

    // R9 fast command clocking
    f0 = fires;
    fast_mode = 1'b1;
    for (int i = 0; i < 200; i++) pulse(1, 1);
    for (int i = 0; i < 100; i++) pulse(2, 2);
    for (int i = 0; i < 50; i++) pulse(A_LO, A_LO);
    fast_mode = 1'b0;
    chk(fast_bad == 0, "R9 fast clocking idle", fast_bad, 0);
    chk((fires - f0) == 0, "R9 fast clocking no fire", fires - f0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule